// File: doc/BRIEF.md
# Elapsed Active Time Accumulator

This block measures how long an activity input stays asserted. While the input is high, a 32-bit working count advances by one on every cycle in which a timebase tick enable is present. The count stops at all ones and does not wrap. Each time the activity input falls, the count is committed to a shadow register. The shadow register stands in for a persistent copy, and only a cold reset clears it.

A small register port lets a host read the count, the shadow copy and an alarm status. The same port lets the host read and write a 32-bit threshold. The host may overwrite the count only while the activity input is low. Such a write updates the count and the shadow copy in the same cycle, so writing zero clears the accumulated time. After a warm reset, the count is restored from the shadow copy.

A compare stage raises the alarm when the working count is equal to or greater than a nonzero threshold. A zero threshold turns the compare off.

Top module: `elapsed_time_accum`

## Requirements
- R1: While `active_i` is high, the count rises by exactly one at each clock edge where `tick_en` is high. While `active_i` is low, ticks leave the count unchanged.
- R2: The count saturates at 0xFFFFFFFF. Further ticks leave it at that value.
- R3: At the clock edge where `active_i` is first seen low after being high, the shadow copy (read address 2) takes the count value that was held just before that edge.
- R4: A write to address 0 while `active_i` is low sets both the count and the shadow copy to the written data. Both are readable at the next cycle. Writing zero clears the accumulated time.
- R5: A write to address 0 while `active_i` is high has no effect on the count or on the shadow copy.
- R6: The threshold at address 1 is readable and writable, and it resets to zero. A zero threshold keeps `alarm_o` low whatever the count.
- R7: With a nonzero threshold, `alarm_o` is high exactly when count >= threshold. It follows the registered values in the same cycle, and it falls again when the count is written below the threshold.
- R8: A warm reset (`rst_n` low) clears the threshold and reloads the count from the preserved shadow copy. A cold reset (`por_n` low) clears both the count and the shadow copy.
- R9: A read of address 3 returns the alarm state in bit 0 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, asynchronous active low, clears the shadow copy too |
| rst_n | input | 1 | Warm reset, asynchronous active low, keeps the shadow copy |
| tick_en | input | 1 | Timebase tick enable, one clock wide per tick |
| active_i | input | 1 | Activity level being timed, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 count, 1 threshold, 2 shadow, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| alarm_o | output | 1 | Alarm flag |

## Verification
The count, the shadow copy and the threshold each change at the first clock edge after the input that causes the change. Read data and `alarm_o` follow those registers with no added delay. The bench therefore drives inputs on the falling clock edge and checks at the next falling edge, one register stage later. After either reset is released, the reset takes two synchronizer cycles plus one reload cycle to complete, so the bench waits four cycles before its first read. The alarm sweep sets every threshold and count pair from 0 to 7 and compares the result with the formula in R7. Further checks cover the threshold at all ones and an alarm reached by counting ticks.

// File: rtl/eta_pkg.sv
package eta_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_THRESH = 2'd1,
    REG_SHADOW = 2'd2,
    REG_STATUS = 2'd3
  } eta_reg_e;
endpackage

// File: rtl/eta_rst_sync.sv
module eta_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eta_fall_det.sv
module eta_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/eta_counter.sv
module eta_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_rst_n,
  input  logic             active_i,
  input  logic             tick_en,
  input  logic             fall_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] shadow_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] shd_q, shd_d;
  logic             load_q;
  logic             wr_ok;
  logic             inc_en;
  logic             cnt_en, shd_en;

  assign wr_ok  = wr_i & ~active_i;
  assign inc_en = active_i & tick_en & (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d  = cnt_q;
    shd_d  = shd_q;
    cnt_en = 1'b0;
    shd_en = 1'b0;
    if (load_q) begin
      cnt_d  = shd_q;
      cnt_en = 1'b1;
    end else if (wr_ok) begin
      cnt_d  = wdata_i;
      shd_d  = wdata_i;
      cnt_en = 1'b1;
      shd_en = 1'b1;
    end else begin
      if (fall_i) begin
        shd_d  = cnt_q;
        shd_en = 1'b1;
      end
      if (inc_en) begin
        cnt_d  = cnt_q + CNT_ONE;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) shd_q <= '0;
    else if (shd_en) shd_q <= shd_d;
  end

  assign cnt_o    = cnt_q;
  assign shadow_o = shd_q;
  assign load_o   = load_q;
endmodule

// File: rtl/eta_regs.sv
module eta_regs
  import eta_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  shadow_i,
  output logic [CNT_W-1:0]  thr_o,
  output logic              alarm_o,
  output logic [CNT_W-1:0]  rdata_o
);
  logic [CNT_W-1:0] thr_q;
  logic             thr_en;

  assign thr_en = we_i & (addr_i == REG_THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_en) thr_q <= wdata_i;
  end

  assign alarm_o = (thr_q != '0) && (cnt_i >= thr_q);

  always_comb begin
    unique case (addr_i)
      REG_COUNT:  rdata_o = cnt_i;
      REG_THRESH: rdata_o = thr_q;
      REG_SHADOW: rdata_o = shadow_i;
      default:    rdata_o = {{(CNT_W-1){1'b0}}, alarm_o};
    endcase
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/elapsed_time_accum.sv
module elapsed_time_accum
  import eta_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              active_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              alarm_o
);
  logic             cold_rst_s;
  logic             sys_rst_s;
  logic             fall_w;
  logic             wr_cnt_w;
  logic             load_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] shadow_w;
  logic [CNT_W-1:0] thr_w;

  eta_rst_sync #(.STAGES(SYNC_STGS)) u_cold_sync (
    .clk(clk), .arst_n(por_n), .rst_n_o(cold_rst_s)
  );

  eta_rst_sync #(.STAGES(SYNC_STGS)) u_sys_sync (
    .clk(clk), .arst_n(por_n & rst_n), .rst_n_o(sys_rst_s)
  );

  eta_fall_det u_fall (
    .clk(clk), .rst_n(sys_rst_s), .level_i(active_i), .fall_o(fall_w)
  );

  assign wr_cnt_w = bus_we & (bus_addr == REG_COUNT);

  eta_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(sys_rst_s), .cold_rst_n(cold_rst_s),
    .active_i(active_i), .tick_en(tick_en), .fall_i(fall_w),
    .wr_i(wr_cnt_w), .wdata_i(bus_wdata),
    .cnt_o(cnt_w), .shadow_o(shadow_w), .load_o(load_w)
  );

  eta_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(sys_rst_s), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .cnt_i(cnt_w), .shadow_i(shadow_w),
    .thr_o(thr_w), .alarm_o(alarm_o), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/eta_accum_chk.sv
module eta_accum_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             sys_rst_s,
  input logic             tick_en,
  input logic             active_i,
  input logic             wr_cnt_w,
  input logic             fall_w,
  input logic             load_w,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] shadow_w,
  input logic [CNT_W-1:0] thr_w,
  input logic             alarm_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && active_i && tick_en && cnt_w != TOP) |=>
      cnt_w == $past(cnt_w) + {{(CNT_W-1){1'b0}}, 1'b1});

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && !active_i && !wr_cnt_w) |=> $stable(cnt_w));

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && active_i && cnt_w == TOP) |=> cnt_w == TOP);

  // R3
  fall_commit_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && fall_w && !wr_cnt_w) |=> shadow_w == $past(cnt_w));

  // R4
  wr_apply_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && wr_cnt_w && !active_i) |=>
      (cnt_w == $past(bus_wdata) && shadow_w == $past(bus_wdata)));

  // R5
  wr_block_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!load_w && active_i) |=> $stable(shadow_w));

  // R6
  alarm_off_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (thr_w == '0) |-> !alarm_o);

  // R7
  alarm_rise_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    $rose(alarm_o) |-> (thr_w != '0 && cnt_w >= thr_w));
endmodule

bind elapsed_time_accum eta_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .sys_rst_s(sys_rst_s), .tick_en(tick_en), .active_i(active_i),
  .wr_cnt_w(wr_cnt_w), .fall_w(fall_w), .load_w(load_w),
  .bus_wdata(bus_wdata), .cnt_w(cnt_w), .shadow_w(shadow_w),
  .thr_w(thr_w), .alarm_o(alarm_o)
);

// File: tb/sim_elapsed_time_accum.sv
module sim_elapsed_time_accum;
  logic        clk = 1'b0;
  logic        por_n, rst_n, tick_en, active_i, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        alarm_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [31:0] exp_cnt, exp_shd;

  always #10 clk = ~clk;

  elapsed_time_accum u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .active_i(active_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_o(alarm_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic chk_regs(input string req, input logic [31:0] c, input logic [31:0] s);
    logic [31:0] v;
    rd(2'd0, v); chk(req, v, c);
    rd(2'd2, v); chk(req, v, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    por_n = 0; rst_n = 0; tick_en = 0; active_i = 0;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (4) step();
    por_n = 1; rst_n = 1;
    repeat (4) step();

    // R8 cold reset state
    chk_regs("R8", 32'd0, 32'd0);
    rd(2'd1, v); chk("R8", v, 32'd0);
    chk("R6", {31'd0, alarm_o}, 32'd0);

    // R1 counting under a tick pattern
    exp_cnt = 0;
    active_i = 1;
    for (int i = 0; i < 64; i++) begin
      tick_en = (i % 3 != 0);
      step();
      if (i % 3 != 0) exp_cnt++;
      rd(2'd0, v); chk("R1", v, exp_cnt);
    end
    // R3 fall commits, R1 no counting while low
    active_i = 0; tick_en = 1;
    step();
    exp_shd = exp_cnt;
    chk_regs("R3", exp_cnt, exp_shd);
    repeat (5) step();
    chk_regs("R1", exp_cnt, exp_shd);

    // R5 write ignored while active
    active_i = 1; tick_en = 0;
    step();
    wr(2'd0, 32'd5);
    chk_regs("R5", exp_cnt, exp_shd);
    active_i = 0;
    step();
    // R4 write while low
    wr(2'd0, 32'd1234);
    chk_regs("R4", 32'd1234, 32'd1234);
    wr(2'd0, 32'd0);
    chk_regs("R4", 32'd0, 32'd0);

    // R2 saturation
    wr(2'd0, 32'hFFFF_FFFD);
    exp_cnt = 32'hFFFF_FFFD;
    active_i = 1; tick_en = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      if (exp_cnt != 32'hFFFF_FFFF) exp_cnt++;
      rd(2'd0, v); chk("R2", v, exp_cnt);
    end
    active_i = 0; tick_en = 0;
    step();

    // R6/R7/R9 sweep of small threshold and count values
    for (int t = 0; t < 8; t++) begin
      wr(2'd1, t);
      rd(2'd1, v); chk("R6", v, t);
      for (int c = 0; c < 8; c++) begin
        logic e;
        wr(2'd0, c);
        e = (t != 0) && (c >= t);
        chk(t == 0 ? "R6" : "R7", {31'd0, alarm_o}, {31'd0, e});
        rd(2'd3, v); chk("R9", v, {31'd0, e});
      end
    end
    // R7 extreme threshold
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFE);
    chk("R7", {31'd0, alarm_o}, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R7", {31'd0, alarm_o}, 32'd1);
    // R7 alarm reached by counting, cleared by lower write
    wr(2'd1, 32'd10);
    wr(2'd0, 32'd8);
    active_i = 1; tick_en = 1;
    step(); chk("R7", {31'd0, alarm_o}, 32'd0);
    step(); chk("R7", {31'd0, alarm_o}, 32'd1);
    active_i = 0; tick_en = 0;
    step();
    wr(2'd0, 32'd3);
    chk("R7", {31'd0, alarm_o}, 32'd0);

    // R8 warm reset reloads from shadow
    wr(2'd0, 32'd100);
    active_i = 1; tick_en = 1;
    repeat (10) step();
    active_i = 0;
    step();
    active_i = 1;
    repeat (5) step();
    chk_regs("R8", 32'd115, 32'd110);
    rst_n = 0;
    step();
    active_i = 0; tick_en = 0;
    step();
    rst_n = 1;
    repeat (4) step();
    chk_regs("R8", 32'd110, 32'd110);
    rd(2'd1, v); chk("R8", v, 32'd0);
    // R8 cold reset clears the shadow copy
    por_n = 0;
    step(); step();
    por_n = 1;
    repeat (4) step();
    chk_regs("R8", 32'd0, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule